// File: doc/BRIEF.md
# GPIO Expander Register Bank

This block is the register file of a 24-pin GPIO expander. It sits behind a simple byte-wide register port made of an address, write data, a write strobe, a read strobe and read data. The pads form a main bank of 16 pins (0..15) and an alternate bank of 8 pins (16..23). For each pin the block holds a direction, an output value, a drive type and a pull select. From these it drives the pad output enable, the pad output value and the pull-up and pull-down enables. Pad inputs pass through a synchronizer and can be read back as state bytes.

Fixed registers return an identity byte and two firmware version bytes. The identity byte is derived from the address-select strap. A system control register enables each bank and starts a software reset. After a software reset the block stays busy for a parameterized number of cycles, and during that window it ignores writes.

Top module: `gpx_regbank`

## Requirements
- R1: After rst_ni is released, every pad_oe_o, pad_out_o, pad_pu_o and pad_pd_o bit is 0, busy_o is 0, and the direction, type and pull registers read 0x00.
- R2: Each per-pin function uses three consecutive byte registers, and pin n sits at base + n/8, bit n%8. The bases are: state 0x10, direction 0x60, type 0x64, pull 0x68, output-set 0x6C, output-clear 0x70. Direction, type and pull read back what was written.
- R3: A direction bit of 1 makes an enabled pin an output and a 0 makes it an input. A push-pull output drives pad_oe_o=1 with pad_out_o equal to its output value.
- R4: Writing to an output-set byte sets the output value of every pin whose data bit is 1. Writing to an output-clear byte clears the output value of every pin whose data bit is 1. Pins whose data bit is 0 keep their value.
- R5: Address 0x00 reads the complement of the 8-bit bus address {7'h42 + addr_sel_i, 1'b0}. This gives 0x7B for strap 0 and 0x79 for strap 1.
- R6: Address 0x01 reads parameter FW_MAJOR and address 0x02 reads parameter FW_MINOR.
- R7: At address 0x40, bit 0 enables pins 0..15 and bit 3 enables pins 16..23. A pin in a disabled bank drives no output enable, no output and no pull, and reads 0 in the state registers. Reads of 0x40 return bits 0 and 3 as written, bit 7 as busy_o, and the other bits as 0.
- R8: On an enabled input pin, a type bit of 0 means no pull. A type bit of 1 turns on a pull: pull-up when the pull bit is 1 and pull-down when it is 0. Pull-up and pull-down are never both on.
- R9: A type bit of 1 on an enabled output pin makes it open-drain. An output value of 0 drives low (pad_oe_o=1, pad_out_o=0). An output value of 1 releases the pad (pad_oe_o=0).
- R10: A level on pad_in_i becomes visible in the state registers (0x10..0x12) after two rising clock edges.
- R11: Writing 0x40 with bit 7 set clears the direction, type, pull, output and enable registers. busy_o is then high for exactly BOOT_CYCLES cycles, bit 7 reads 1 during that window, and every write made while busy_o is high is ignored.
- R12: Reads of unmapped addresses and of the output-set and output-clear registers return 0x00. Writes to read-only or unmapped addresses change nothing.
- R13: rdata_o is updated on the clock edge that samples rd_i and holds its value while rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_sel_i | input | 1 | Bus address strap |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| busy_o | output | 1 | Boot window after a software reset |
| pad_in_i | input | 24 | Raw pad input levels |
| pad_oe_o | output | 24 | Pad output enables |
| pad_out_o | output | 24 | Pad output values |
| pad_pu_o | output | 24 | Pull-up enables |
| pad_pd_o | output | 24 | Pull-down enables |

## Verification
Random writes to the direction, type, pull, set, clear and bank-enable registers produce a wide mix of pin states. After every write, each pad output is compared against a model, which separates push-pull, open-drain, pulled-input and disabled-bank behaviour pin by pin. Random reads across the whole 0x00..0x7F address space are made with a settled random pad input. They cover the state bytes, the unmapped holes such as 0x63 and the zero-reading set/clear registers. Directed cases cover both address straps, set and clear masks on single lanes, the exact length of the busy window, and a write made during the busy window, which must leave no trace.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int unsigned NUM_PINS  = 24;
  localparam int unsigned MAIN_PINS = 16;
  localparam int unsigned LANE_W    = 8;
  localparam int unsigned NUM_LANES = NUM_PINS / LANE_W;

  localparam logic [7:0] A_ID      = 8'h00;
  localparam logic [7:0] A_FW_HI   = 8'h01;
  localparam logic [7:0] A_FW_LO   = 8'h02;
  localparam logic [7:0] A_STATE   = 8'h10;
  localparam logic [7:0] A_SYS     = 8'h40;
  localparam logic [7:0] A_DIR     = 8'h60;
  localparam logic [7:0] A_TYPE    = 8'h64;
  localparam logic [7:0] A_PULL    = 8'h68;
  localparam logic [7:0] A_SET     = 8'h6C;
  localparam logic [7:0] A_CLR     = 8'h70;

  localparam int unsigned SYS_MAIN_EN = 0;
  localparam int unsigned SYS_ALT_EN  = 3;
  localparam int unsigned SYS_SWRST   = 7;

  localparam logic [6:0] BUS_ADDR_BASE = 7'h42;

  function automatic logic [7:0] chip_id(input logic sel);
    logic [6:0] a7;
    a7 = BUS_ADDR_BASE + {6'd0, sel};
    return ~{a7, 1'b0};
  endfunction
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpx_boot_timer.sv
module gpx_boot_timer #(
  parameter int unsigned BOOT_CYCLES = 2_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(BOOT_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(BOOT_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  a_r11_busy_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  a_r11_busy_ends_at_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(cnt_q) == CW'(1));
endmodule

// File: rtl/gpx_pad_drive.sv
module gpx_pad_drive #(
  parameter int unsigned NP   = 24,
  parameter int unsigned NM   = 16
) (
  input  logic          main_en_i,
  input  logic          alt_en_i,
  input  logic [NP-1:0] dir_i,
  input  logic [NP-1:0] type_i,
  input  logic [NP-1:0] pull_i,
  input  logic [NP-1:0] out_i,
  output logic [NP-1:0] en_o,
  output logic [NP-1:0] oe_o,
  output logic [NP-1:0] dout_o,
  output logic [NP-1:0] pu_o,
  output logic [NP-1:0] pd_o
);
  for (genvar p = 0; p < NP; p++) begin : g_pin
    logic en;
    if (p < NM) begin : g_main
      assign en = main_en_i;
    end else begin : g_alt
      assign en = alt_en_i;
    end
    assign en_o[p]   = en;
    // open-drain high releases the pad
    assign oe_o[p]   = en &  dir_i[p] & ~(type_i[p] & out_i[p]);
    assign dout_o[p] = en &  dir_i[p] & ~type_i[p] & out_i[p];
    assign pu_o[p]   = en & ~dir_i[p] &  type_i[p] &  pull_i[p];
    assign pd_o[p]   = en & ~dir_i[p] &  type_i[p] & ~pull_i[p];
  end

  always_comb begin
    a_r8_no_both_pulls: assert ((pu_o & pd_o) == '0);
  end
endmodule

// File: rtl/gpx_regbank.sv
module gpx_regbank
  import gpx_pkg::*;
#(
  parameter int unsigned BOOT_CYCLES = 2_500_000,
  parameter logic [7:0]  FW_MAJOR    = 8'h02,
  parameter logic [7:0]  FW_MINOR    = 8'h01
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                addr_sel_i,
  input  logic [7:0]          addr_i,
  input  logic [7:0]          wdata_i,
  input  logic                wr_i,
  input  logic                rd_i,
  output logic [7:0]          rdata_o,
  output logic                busy_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_pu_o,
  output logic [NUM_PINS-1:0] pad_pd_o
);
  logic                wr_ok, soft_rst;
  logic                main_en_q, alt_en_q;
  logic [7:0]          dir_q  [NUM_LANES];
  logic [7:0]          type_q [NUM_LANES];
  logic [7:0]          pull_q [NUM_LANES];
  logic [7:0]          out_q  [NUM_LANES];
  logic [NUM_PINS-1:0] dir_v, type_v, pull_v, out_v, en_v, sync_v, state_v;
  logic [7:0]          rd_mux, rdata_q;

  assign wr_ok    = wr_i & ~busy_o;
  assign soft_rst = wr_ok & (addr_i == A_SYS) & wdata_i[SYS_SWRST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_en_q <= 1'b0;
      alt_en_q  <= 1'b0;
    end else if (soft_rst) begin
      main_en_q <= 1'b0;
      alt_en_q  <= 1'b0;
    end else if (wr_ok && addr_i == A_SYS) begin
      main_en_q <= wdata_i[SYS_MAIN_EN];
      alt_en_q  <= wdata_i[SYS_ALT_EN];
    end
  end

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    localparam logic [7:0] K = 8'(k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni || soft_rst) begin
        dir_q[k]  <= '0;
        type_q[k] <= '0;
        pull_q[k] <= '0;
        out_q[k]  <= '0;
      end else if (wr_ok) begin
        if (addr_i == A_DIR  + K) dir_q[k]  <= wdata_i;
        if (addr_i == A_TYPE + K) type_q[k] <= wdata_i;
        if (addr_i == A_PULL + K) pull_q[k] <= wdata_i;
        if (addr_i == A_SET  + K) out_q[k]  <= out_q[k] | wdata_i;
        if (addr_i == A_CLR  + K) out_q[k]  <= out_q[k] & ~wdata_i;
      end
    end
    assign dir_v [k*LANE_W +: LANE_W] = dir_q[k];
    assign type_v[k*LANE_W +: LANE_W] = type_q[k];
    assign pull_v[k*LANE_W +: LANE_W] = pull_q[k];
    assign out_v [k*LANE_W +: LANE_W] = out_q[k];

    a_r4_set_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ok && addr_i == A_SET + K) |=> ((out_q[k] & $past(wdata_i)) == $past(wdata_i)));
    a_r4_clr_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ok && addr_i == A_CLR + K) |=> ((out_q[k] & $past(wdata_i)) == 8'h00));
    a_r11_busy_ignores_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && wr_i && addr_i == A_DIR + K) |=> $stable(dir_q[k]));
  end

  gpx_sync #(.W(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (sync_v)
  );

  gpx_boot_timer #(.BOOT_CYCLES(BOOT_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(soft_rst),
    .busy_o (busy_o)
  );

  gpx_pad_drive #(.NP(NUM_PINS), .NM(MAIN_PINS)) u_drive (
    .main_en_i(main_en_q),
    .alt_en_i (alt_en_q),
    .dir_i    (dir_v),
    .type_i   (type_v),
    .pull_i   (pull_v),
    .out_i    (out_v),
    .en_o     (en_v),
    .oe_o     (pad_oe_o),
    .dout_o   (pad_out_o),
    .pu_o     (pad_pu_o),
    .pd_o     (pad_pd_o)
  );

  assign state_v = sync_v & en_v;

  always_comb begin
    rd_mux = 8'h00;
    unique case (addr_i)
      A_ID:      rd_mux = chip_id(addr_sel_i);
      A_FW_HI:   rd_mux = FW_MAJOR;
      A_FW_LO:   rd_mux = FW_MINOR;
      A_SYS:     rd_mux = {busy_o, 3'b000, alt_en_q, 2'b00, main_en_q};
      A_STATE,   A_STATE + 8'd1, A_STATE + 8'd2:
        rd_mux = state_v[(addr_i - A_STATE)*LANE_W +: LANE_W];
      A_DIR,     A_DIR + 8'd1,   A_DIR + 8'd2:   rd_mux = dir_q [addr_i - A_DIR];
      A_TYPE,    A_TYPE + 8'd1,  A_TYPE + 8'd2:  rd_mux = type_q[addr_i - A_TYPE];
      A_PULL,    A_PULL + 8'd1,  A_PULL + 8'd2:  rd_mux = pull_q[addr_i - A_PULL];
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= 8'h00;
    else if (rd_i) rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;

  a_r13_read_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  a_r11_soft_rst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (busy_o && pad_oe_o == '0 && pad_pu_o == '0 && pad_pd_o == '0));
  a_r7_main_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !main_en_q |-> (pad_oe_o[MAIN_PINS-1:0] == '0 && pad_pu_o[MAIN_PINS-1:0] == '0));
  a_r7_alt_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alt_en_q |-> (pad_oe_o[NUM_PINS-1:MAIN_PINS] == '0 && pad_pd_o[NUM_PINS-1:MAIN_PINS] == '0));
endmodule

// File: tb/gpx_regbank_tb_top.sv
module gpx_regbank_tb_top;
  localparam int unsigned BOOT = 40;
  localparam logic [7:0] FWH = 8'h02, FWL = 8'h01;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel = 1'b0;
  logic [7:0]  addr = '0, wdata = '0, rdata;
  logic        wr = 1'b0, rd = 1'b0, busy;
  logic [23:0] pin = '0, oe, dout, pu, pd;

  int n_chk = 0, n_fail = 0, cyc = 0;

  logic [23:0] m_dir = '0, m_typ = '0, m_pul = '0, m_out = '0;
  logic        m_en0 = 1'b0, m_en1 = 1'b0;

  always #2 clk = ~clk;

  gpx_regbank #(.BOOT_CYCLES(BOOT), .FW_MAJOR(FWH), .FW_MINOR(FWL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_sel_i(sel), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .busy_o(busy), .pad_in_i(pin),
    .pad_oe_o(oe), .pad_out_o(dout), .pad_pu_o(pu), .pad_pd_o(pd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] enm();
    return {{8{m_en1}}, {16{m_en0}}};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    logic [23:0] st;
    st = pin & enm();
    case (a)
      8'h00: return ~{7'h42 + {6'd0, sel}, 1'b0};
      8'h01: return FWH;
      8'h02: return FWL;
      8'h10, 8'h11, 8'h12: return st[(a - 8'h10)*8 +: 8];
      8'h40: return {busy, 3'b000, m_en1, 2'b00, m_en0};
      8'h60, 8'h61, 8'h62: return m_dir[(a - 8'h60)*8 +: 8];
      8'h64, 8'h65, 8'h66: return m_typ[(a - 8'h64)*8 +: 8];
      8'h68, 8'h69, 8'h6A: return m_pul[(a - 8'h68)*8 +: 8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    logic b;
    @(negedge clk);
    b = busy;
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (!b) begin
      case (a)
        8'h40: if (d[7]) begin
                 m_dir = '0; m_typ = '0; m_pul = '0; m_out = '0; m_en0 = 0; m_en1 = 0;
               end else begin
                 m_en0 = d[0]; m_en1 = d[3];
               end
        8'h60, 8'h61, 8'h62: m_dir[(a - 8'h60)*8 +: 8] = d;
        8'h64, 8'h65, 8'h66: m_typ[(a - 8'h64)*8 +: 8] = d;
        8'h68, 8'h69, 8'h6A: m_pul[(a - 8'h68)*8 +: 8] = d;
        8'h6C, 8'h6D, 8'h6E: m_out[(a - 8'h6C)*8 +: 8] |= d;
        8'h70, 8'h71, 8'h72: m_out[(a - 8'h70)*8 +: 8] &= ~d;
        default: ;
      endcase
    end
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic chk_pads(input string tag);
    logic [23:0] e;
    e = enm();
    chk({tag, " oe"},  oe,   e & m_dir & ~(m_typ & m_out));
    chk({tag, " out"}, dout, e & m_dir & ~m_typ & m_out);
    chk({tag, " pu"},  pu,   e & ~m_dir & m_typ & m_pul);
    chk({tag, " pd"},  pd,   e & ~m_dir & m_typ & ~m_pul);
  endtask

  task automatic chk_rd(input string tag, input logic [7:0] a);
    logic [7:0] v, e;
    do_rd(a, v);
    e = exp_rd(a);
    chk($sformatf("%s @%02h", tag, a), v, e);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_pads("R1 reset");
    chk("R1 busy", busy, 1'b0);
    chk_rd("R1 dir", 8'h60);
    chk_rd("R1 type", 8'h66);

    // R5 ID for both straps, R6 firmware
    sel = 1'b0; do_rd(8'h00, v); chk("R5 id sel0", v, 8'h7B);
    sel = 1'b1; do_rd(8'h00, v); chk("R5 id sel1", v, 8'h79);
    sel = 1'b0;
    chk_rd("R6 fw hi", 8'h01);
    chk_rd("R6 fw lo", 8'h02);

    // R7 enables, R3 push-pull outputs, R2 lane layout
    do_wr(8'h40, 8'h09);
    chk_rd("R7 sys", 8'h40);
    do_wr(8'h61, 8'h81);             // pins 8 and 15 outputs
    do_wr(8'h6D, 8'h01);             // pin 8 high
    chk_pads("R3 push-pull");
    chk("R2 pin8 out", dout[8], 1'b1);
    // R4 set/clear masks
    do_wr(8'h6D, 8'h80);
    do_wr(8'h71, 8'h01);
    chk("R4 set/clr", dout[15:8], 8'h80);
    // R9 open-drain
    do_wr(8'h65, 8'h80);
    chk("R9 od high released", oe[15], 1'b0);
    do_wr(8'h71, 8'h80);
    chk("R9 od low drives", {oe[15], dout[15]}, 2'b10);
    // R8 pulls on alternate bank inputs
    do_wr(8'h66, 8'h03);
    do_wr(8'h6A, 8'h01);
    chk("R8 pu", pu[17:16], 2'b01);
    chk("R8 pd", pd[17:16], 2'b10);
    // R7 disabling alt bank quiets it
    do_wr(8'h40, 8'h01);
    chk("R7 alt off", pu[23:16] | pd[23:16], 8'h00);
    chk_pads("R7 alt off");

    // R10 synchronizer latency
    do_wr(8'h40, 8'h09);
    @(negedge clk); pin = 24'hA5C3_3C;
    @(negedge clk); addr = 8'h10; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    chk("R10 one edge not yet", rdata, 8'h00);
    chk_rd("R10 state0", 8'h10);
    chk_rd("R10 state2", 8'h12);

    // R12 unmapped and set/clear reads, read-only write
    chk_rd("R12 set read", 8'h6C);
    chk_rd("R12 hole", 8'h63);
    do_wr(8'h00, 8'hFF);
    do_wr(8'h10, 8'hFF);
    chk_rd("R12 ro write", 8'h00);
    chk_pads("R12 ro write");

    // R13 read data holds without rd
    do_rd(8'h01, v);
    @(negedge clk); addr = 8'h00;
    @(negedge clk);
    chk("R13 hold", rdata, FWH);

    // R11 soft reset: busy length
    do_wr(8'h40, 8'h80);
    chk_pads("R11 cleared");
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk("R11 busy len", n, BOOT);
    chk_rd("R11 sys after", 8'h40);

    // R11 writes ignored during busy, bit7 reads 1
    do_wr(8'h40, 8'h80);
    do_wr(8'h60, 8'hFF);
    do_wr(8'h40, 8'h09);
    do_rd(8'h40, v); chk("R11 sys busy", v, 8'h80);
    chk_rd("R11 dir ignored", 8'h60);
    while (busy) @(negedge clk);
    chk_pads("R11 after busy");

    // random mix (R2 R3 R4 R7 R8 R9 R12)
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, d;
      int op;
      op = $urandom % 7;
      d  = 8'($urandom);
      case (op)
        0: a = 8'h60 + 8'($urandom % 3);
        1: a = 8'h64 + 8'($urandom % 3);
        2: a = 8'h68 + 8'($urandom % 3);
        3: a = 8'h6C + 8'($urandom % 3);
        4: a = 8'h70 + 8'($urandom % 3);
        5: begin a = 8'h40; d = d & 8'h7F; end
        default: a = 8'($urandom % 128);
      endcase
      if (a == 8'h40) d = d & 8'h7F;
      do_wr(a, d);
      chk_pads("R2 random pads");
      if (i % 4 == 0) begin
        pin = 24'($urandom);
        repeat (3) @(negedge clk);
        chk_rd("R12 random read", 8'($urandom % 128));
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule